// File: doc/BRIEF.md
# Three-Tap Polyphase Vertical Upscaling Filter

This block produces the output lines of a 2.5x vertical enlargement of single-channel 8-bit monochrome video. Two source lines become five output lines. For each output pixel, the block takes the pixel at the same column from three vertically adjacent source lines. It forms a weighted sum of the three, rounds it, clamps it and returns one 8-bit result per clock. Line buffers upstream present the three source pixels already aligned.

The weights come from a table that holds five phases of three signed coefficients each. The table is a strapped input of 15 entries that is meant to stay constant. A small state machine picks the phase: one step per output line, restarting at each frame. Loading different table contents changes the filter character, for example soft linear interpolation, a cubic-like kernel with negative side lobes, or hard pixel replication.

The phase state machine has six states:
- `ST_WAIT`: after reset or a frame restart, waiting for the first line. Pixels in this state use phase 0 weights.
- `ST_P0` to `ST_P4`: the five line phases.

The transitions are:
- `frame_start` goes to `ST_WAIT` from any state.
- `line_start` goes from `ST_WAIT` to `ST_P0`, from `ST_Pn` to `ST_Pn+1`, and from `ST_P4` back to `ST_P0`.
- With neither input asserted, the state holds.

Top module: `vscale_tap3`

## Requirements
- R1: During and after reset, until the first valid result leaves the pipeline, `out_valid` is 0 and `pix_out` is 0.
- R2: A valid result equals clamp(floor((k0·pix_a + k1·pix_b + k2·pix_c + 128) / 256)). Here kt is the signed 10-bit field `coef_tbl[10*(3*p+t) +: 10]` and p is the active phase, with `ST_WAIT` using p = 0. The pixels are unsigned.
- R3: A pixel presented with `in_valid` high produces its result with `out_valid` high exactly two clock edges later. Back-to-back pixels give back-to-back results.
- R4: After reset or a frame restart, the first `line_start` selects phase 0. Each later `line_start` advances the phase by one, and phase 4 wraps to phase 0.
- R5: `frame_start` returns the phase machine to `ST_WAIT`. It takes priority over a `line_start` in the same cycle.
- R6: A pixel presented in the same cycle as `line_start` is filtered with the phase that was active before that edge.
- R7: Sums below 0 give an output of 0, and sums above 255 give an output of 255.
- R8: While no result is delivered (`out_valid` low), `pix_out` keeps its last delivered value.
- R9: Only the table contents differ between linear, cubic-like and replicating (single coefficient 256) behaviour. Each table gives its own R2 result in every phase.
- R10: Rounding is to nearest with halves upward: a weight of 1 on 128 gives 1, and a weight of 1 on 127 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Restart the phase sequence |
| line_start | input | 1 | Begin the next output line (advance phase) |
| coef_tbl | input | 150 | Five phases by three signed 10-bit weights, entry 3*phase+tap |
| in_valid | input | 1 | The three input pixels are valid |
| pix_a | input | 8 | Source pixel from the upper line (tap 0) |
| pix_b | input | 8 | Source pixel from the middle line (tap 1) |
| pix_c | input | 8 | Source pixel from the lower line (tap 2) |
| out_valid | output | 1 | `pix_out` carries a new result |
| pix_out | output | 8 | Filtered output pixel |

## Verification
Three tables are each swept over all five phases with every combination of the pixel values 0, 1, 127, 128 and 255:
- A linear table separates the tap order and the weight indexing.
- A cubic table with negative weights exposes sign handling.
- A replicating table shows whether a single unity weight passes the pixel through unchanged.

Extreme-weight tables drive the clamp at both ends. A unit-weight table probes the rounding boundary. Sequences that place `line_start` and `frame_start` together, or `line_start` on a valid pixel, show whether the phase is taken before or after the edge and which control input wins.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    localparam int PHASES = 5;
    localparam int TAPS   = 3;
    localparam int PH_W   = $clog2(PHASES);

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_P0   = 3'd1,
        ST_P1   = 3'd2,
        ST_P2   = 3'd3,
        ST_P3   = 3'd4,
        ST_P4   = 3'd5
    } phase_st_t;
endpackage

// File: rtl/vsc_phase_fsm.sv
module vsc_phase_fsm
    import vsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            line_start,
    output phase_st_t       state,
    output logic [PH_W-1:0] phase_idx
);
    phase_st_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (frame_start) begin
            nxt = ST_WAIT;
        end else if (line_start) begin
            unique case (state)
                ST_WAIT: nxt = ST_P0;
                ST_P0:   nxt = ST_P1;
                ST_P1:   nxt = ST_P2;
                ST_P2:   nxt = ST_P3;
                ST_P3:   nxt = ST_P4;
                ST_P4:   nxt = ST_P0;
                default: nxt = ST_WAIT;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_WAIT: phase_idx = PH_W'(0);
            ST_P0:   phase_idx = PH_W'(0);
            ST_P1:   phase_idx = PH_W'(1);
            ST_P2:   phase_idx = PH_W'(2);
            ST_P3:   phase_idx = PH_W'(3);
            ST_P4:   phase_idx = PH_W'(4);
            default: phase_idx = PH_W'(0);
        endcase
    end
endmodule

// File: rtl/vsc_coef_sel.sv
module vsc_coef_sel
    import vsc_pkg::*;
#(
    parameter int COEF_W = 10
) (
    input  logic [PHASES*TAPS*COEF_W-1:0] tbl,
    input  logic [PH_W-1:0]               phase_idx,
    output logic [TAPS*COEF_W-1:0]        coefs
);
    logic [PHASES-1:0][TAPS*COEF_W-1:0] rows;

    for (genvar p = 0; p < PHASES; p++) begin : g_row
        assign rows[p] = tbl[p*TAPS*COEF_W +: TAPS*COEF_W];
    end

    always_comb begin
        coefs = rows[0];
        for (int p = 1; p < PHASES; p++) begin
            if (phase_idx == PH_W'(p)) coefs = rows[p];
        end
    end
endmodule

// File: rtl/vsc_mac.sv
module vsc_mac
    import vsc_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int COEF_W    = 10,
    parameter int FRAC_BITS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [TAPS*PIX_W-1:0]    pix,
    input  logic [TAPS*COEF_W-1:0]   coefs,
    output logic                     mid_valid,
    output logic                     out_valid,
    output logic [PIX_W-1:0]         pix_out
);
    localparam int PROD_W = PIX_W + 1 + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(TAPS) + 1;
    localparam int ROUND  = 1 << (FRAC_BITS - 1);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [SUM_W-1:0]  sum, rnd, shifted;
    logic [PIX_W-1:0]         clamped;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic signed [PIX_W:0]    px_s;
        logic signed [COEF_W-1:0] cf_s;
        assign px_s = $signed({1'b0, pix[t*PIX_W +: PIX_W]});
        assign cf_s = $signed(coefs[t*COEF_W +: COEF_W]);
        always_ff @(posedge clk) begin
            if (!rst_n)        prod[t] <= '0;
            else if (in_valid) prod[t] <= px_s * cf_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mid_valid <= 1'b0;
        else        mid_valid <= in_valid;
    end

    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) sum = sum + SUM_W'(prod[t]);
        rnd     = sum + SUM_W'(ROUND);
        shifted = rnd >>> FRAC_BITS;
        if (shifted < 0)         clamped = '0;
        else if (shifted > MAXV) clamped = '1;
        else                     clamped = shifted[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pix_out   <= '0;
        end else begin
            out_valid <= mid_valid;
            if (mid_valid) pix_out <= clamped;
        end
    end
endmodule

// File: rtl/vscale_tap3.sv
module vscale_tap3
    import vsc_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int COEF_W    = 10,
    parameter int FRAC_BITS = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             frame_start,
    input  logic                             line_start,
    input  logic [PHASES*TAPS*COEF_W-1:0]    coef_tbl,
    input  logic                             in_valid,
    input  logic [PIX_W-1:0]                 pix_a,
    input  logic [PIX_W-1:0]                 pix_b,
    input  logic [PIX_W-1:0]                 pix_c,
    output logic                             out_valid,
    output logic [PIX_W-1:0]                 pix_out
);
    phase_st_t               phase_state;
    logic [PH_W-1:0]         phase_idx;
    logic [TAPS*COEF_W-1:0]  coefs;
    logic                    mid_valid;

    vsc_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .state       (phase_state),
        .phase_idx   (phase_idx)
    );

    vsc_coef_sel #(.COEF_W(COEF_W)) u_sel (
        .tbl       (coef_tbl),
        .phase_idx (phase_idx),
        .coefs     (coefs)
    );

    vsc_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_BITS(FRAC_BITS)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .pix       ({pix_c, pix_b, pix_a}),
        .coefs     (coefs),
        .mid_valid (mid_valid),
        .out_valid (out_valid),
        .pix_out   (pix_out)
    );
endmodule

// File: rtl/vsc_checker.sv
module vsc_checker
    import vsc_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             line_start,
    input logic             in_valid,
    input phase_st_t        state,
    input logic             mid_valid,
    input logic             out_valid,
    input logic [PIX_W-1:0] pix_out
);
    assert_frame_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> state == ST_WAIT);

    assert_first_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_start && state == ST_WAIT) |=> state == ST_P0);

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_start && state == ST_P4) |=> state == ST_P0);

    assert_hold_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !line_start) |=> $stable(state));

    assert_stage1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> mid_valid);

    assert_stage2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mid_valid |=> out_valid);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mid_valid |=> !out_valid);

    assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mid_valid |=> $stable(pix_out));
endmodule

bind vscale_tap3 vsc_checker #(.PIX_W(PIX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .in_valid    (in_valid),
    .state       (phase_state),
    .mid_valid   (mid_valid),
    .out_valid   (out_valid),
    .pix_out     (pix_out)
);

// File: tb/vscale_tap3_test.sv
`timescale 1ns/1ps
module vscale_tap3_test;
    logic         clk = 1'b0;
    logic         rst_n, frame_start, line_start, in_valid;
    logic [149:0] tbl;
    logic [7:0]   pix_a, pix_b, pix_c;
    logic         out_valid;
    logic [7:0]   pix_out;

    int checks = 0, errors = 0;
    int mphase = -1;
    bit prev_v = 0;
    int prev_e = 0, last_out = 0;
    bit done = 0;
    int vals [5] = '{0, 1, 127, 128, 255};

    always #2 clk = ~clk;

    vscale_tap3 uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .coef_tbl(tbl), .in_valid(in_valid), .pix_a(pix_a), .pix_b(pix_b), .pix_c(pix_c),
        .out_valid(out_valid), .pix_out(pix_out)
    );

    task automatic setc(input int p, input int c0, input int c1, input int c2);
        tbl[10*(3*p+0) +: 10] = 10'(c0);
        tbl[10*(3*p+1) +: 10] = 10'(c1);
        tbl[10*(3*p+2) +: 10] = 10'(c2);
    endtask

    function automatic int kval(input int p, input int t);
        return int'($signed(tbl[10*(3*p+t) +: 10]));
    endfunction

    function automatic int model(input int a, input int b, input int c);
        int p, s, y;
        p = (mphase < 0) ? 0 : mphase;
        s = kval(p,0)*a + kval(p,1)*b + kval(p,2)*c;
        y = (s + 128) >>> 8;
        if (y < 0) y = 0;
        if (y > 255) y = 255;
        return y;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input bit ls, input bit fs,
                       input int a, input int b, input int c, input string req);
        int e;
        in_valid = v; line_start = ls; frame_start = fs;
        pix_a = 8'(a); pix_b = 8'(b); pix_c = 8'(c);
        e = model(a, b, c);
        if (fs) mphase = -1;
        else if (ls) mphase = (mphase < 0 || mphase == 4) ? 0 : mphase + 1;
        @(negedge clk);
        if (prev_v) begin
            check(out_valid === 1'b1 && int'(pix_out) == prev_e, req, int'(pix_out), prev_e);
            last_out = prev_e;
        end else begin
            check(out_valid === 1'b0 && int'(pix_out) == last_out, "R8", int'(pix_out), last_out);
        end
        prev_v = v; prev_e = e;
    endtask

    task automatic sweep(input string req);
        cyc(0, 0, 1, 0, 0, 0, "R5");
        for (int p = 0; p < 5; p++) begin
            cyc(0, 1, 0, 0, 0, 0, "R4");
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int k = 0; k < 5; k++)
                        cyc(1, 0, 0, vals[i], vals[j], vals[k], req);
        end
        cyc(0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, 0, "R3");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 0; frame_start = 0; line_start = 0; in_valid = 0;
        pix_a = 0; pix_b = 0; pix_c = 0; tbl = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && pix_out === 8'd0, "R1", int'(pix_out), 0);
        rst_n = 1;
        @(negedge clk);
        check(out_valid === 1'b0 && pix_out === 8'd0, "R1", int'(pix_out), 0);

        // R2 R9 linear table
        setc(0, 0, 256, 0);  setc(1, 0, 154, 102); setc(2, 0, 51, 205);
        setc(3, 205, 51, 0); setc(4, 102, 154, 0);
        sweep("R2 linear");
        // R9 cubic-like table with negative side lobes
        setc(0, -20, 256, 20); setc(1, -24, 200, 80); setc(2, 10, 60, 186);
        setc(3, 90, 190, -24); setc(4, 40, 240, -24);
        sweep("R9 cubic");
        // R9 replicating table
        setc(0, 0, 256, 0); setc(1, 0, 256, 0); setc(2, 0, 0, 256);
        setc(3, 256, 0, 0); setc(4, 0, 256, 0);
        sweep("R9 sharp");

        // R6: pixel on the line_start cycle uses previous phase
        setc(0, 256, 0, 0); setc(1, 0, 256, 0); setc(2, 0, 0, 256);
        setc(3, 128, 128, 0); setc(4, 0, 128, 128);
        cyc(0, 0, 1, 0, 0, 0, "R5");
        cyc(1, 1, 0, 10, 20, 30, "R6");
        cyc(1, 1, 0, 10, 20, 30, "R6");
        cyc(1, 1, 0, 10, 20, 30, "R6");
        // R5: frame_start wins over line_start
        cyc(1, 1, 1, 10, 20, 30, "R5");
        cyc(1, 0, 0, 40, 50, 60, "R5");
        cyc(0, 1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 40, 50, 60, "R4");
        for (int n = 0; n < 6; n++) begin
            cyc(0, 1, 0, 0, 0, 0, "R4");
            cyc(1, 0, 0, 70, 80, 90, "R4");
        end
        cyc(0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, 0, "R3");

        // R7 clamp both ends, R10 rounding
        setc(0, 511, 511, 511); setc(1, -512, 0, 0); setc(2, 1, 0, 0);
        setc(3, -1, 0, 0);      setc(4, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, "R5");
        cyc(0, 1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 255, 255, 255, "R7");
        cyc(1, 0, 0, 1, 0, 0, "R7");
        cyc(0, 1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 255, 0, 0, "R7");
        cyc(0, 1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 128, 0, 0, "R10");
        cyc(1, 0, 0, 127, 0, 0, "R10");
        cyc(0, 1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 128, 9, 9, "R10");
        cyc(1, 0, 0, 129, 9, 9, "R10");
        cyc(0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, "R8");
        finish_run();
    end
endmodule